// File: doc/BRIEF.md
# Modulo-3329 Coefficient Add/Subtract Stage

This block adds or subtracts two polynomial coefficients of a lattice-based cryptographic scheme. The result is reduced modulo the prime 3329. Each transaction carries its own operation select. Operands arrive already reduced into 0..3328, and the result is also returned in 0..3328. One conditional correction by the modulus after a single add or subtract is enough to bring it back into range.

The result sits in one pipeline register between a valid/ready input handshake and a valid/ready output handshake. An accepted operand pair produces a result one clock later. The register can take a new pair in the same cycle that the downstream side drains it, so back-to-back traffic runs at one result per clock. When the downstream side stalls, the register holds its result and refuses new work. The reset is synchronous and active low, and it empties the register.

Top module: `modq_addsub`

## Requirements
- R1: In the first cycle after the synchronous active-low reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: With `sub_sel` = 0 the accepted pair yields `res_data` = (a + b) mod 3329.
- R3: With `sub_sel` = 1 the accepted pair yields `res_data` = (a - b) mod 3329, always in 0..3328 even when a < b.
- R4: A pair is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and `out_valid` is 1 after that same edge.
- R5: `in_ready` is 1 exactly when `out_ready` is 1 or `out_valid` is 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `res_data` does not change across the edge.
- R7: When `out_valid` and `out_ready` are both 1 and no pair is accepted, `out_valid` is 0 after the edge.
- R8: Range corners hold: 3328 + 3328 = 3327, 3328 + 1 = 0, 0 - 1 = 3328, a - a = 0.
- R9: A pair offered while `in_ready` is 0 is ignored: the held result stays on `res_data` and no extra result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 12 | First operand, below 3329 |
| opnd_b | input | 12 | Second operand, below 3329 |
| sub_sel | input | 1 | 0 = add, 1 = subtract (a - b) |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Stage can take a pair this cycle |
| res_data | output | 12 | Reduced result |
| out_valid | output | 1 | `res_data` holds a result |
| out_ready | input | 1 | Downstream takes the result |

## Verification
The result assertions assume that both operands are already below 3329 whenever `in_valid` is high. A single correction step is only sufficient under that condition, and the checker states it as an assertion on the input. The bench keeps within this bound. It draws random operands with `$urandom_range(0, 3328)` and mixes in the boundary values 0, 1, 3327 and 3328. The directed corner pairs are all below the modulus. `out_ready` is toggled at random so that stalls, drains and same-cycle refills all occur under this legal stimulus.

// File: rtl/modq_pkg.sv
`timescale 1ns/1ps
package modq_pkg;
   typedef enum logic {
      MQ_OP_ADD = 1'b0,
      MQ_OP_SUB = 1'b1
   } mq_op_e;

   localparam int MQ_DEF_WIDTH   = 12;
   localparam int MQ_DEF_MODULUS = 3329;
endpackage

// File: rtl/modq_corr_core.sv
`timescale 1ns/1ps
module modq_corr_core #(
   parameter int W          = modq_pkg::MQ_DEF_WIDTH,
   parameter int MODULUS    = modq_pkg::MQ_DEF_MODULUS,
   parameter bit SHARED_ADD = 1'b1
) (
   input  logic                 op_sub,
   input  logic [W-1:0]         a,
   input  logic [W-1:0]         b,
   output logic [W-1:0]         r
);
   localparam int        WX    = W + 1;
   localparam logic [W:0] MOD_X = WX'(MODULUS);

   if (SHARED_ADD) begin : g_shared
      // one adder; b is inverted with carry-in for subtraction
      logic [W:0] b_ext;
      logic [W:0] raw;
      logic [W:0] corr;
      logic [W:0] fixed;
      logic       need_fix;
      always_comb begin
         b_ext    = op_sub ? ~{1'b0, b} : {1'b0, b};
         raw      = {1'b0, a} + b_ext + {{W{1'b0}}, op_sub};
         corr     = op_sub ? MOD_X : (~MOD_X + 1'b1);
         fixed    = raw + corr;
         need_fix = op_sub ? raw[W] : (raw >= MOD_X);
         r        = need_fix ? fixed[W-1:0] : raw[W-1:0];
      end
   end else begin : g_dual
      // separate add and subtract paths, muxed at the end
      logic [W:0] sum;
      logic [W:0] sum_fix;
      logic [W:0] diff;
      logic [W:0] diff_fix;
      logic [W-1:0] add_r;
      logic [W-1:0] sub_r;
      always_comb begin
         sum      = {1'b0, a} + {1'b0, b};
         sum_fix  = sum - MOD_X;
         diff     = {1'b0, a} - {1'b0, b};
         diff_fix = diff + MOD_X;
         add_r    = (sum >= MOD_X) ? sum_fix[W-1:0] : sum[W-1:0];
         sub_r    = diff[W] ? diff_fix[W-1:0] : diff[W-1:0];
         r        = op_sub ? sub_r : add_r;
      end
   end
endmodule

// File: rtl/modq_hold_stage.sv
`timescale 1ns/1ps
module modq_hold_stage #(
   parameter int W          = modq_pkg::MQ_DEF_WIDTH,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_valid,
   output logic         up_ready,
   input  logic [W-1:0] up_data,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] dn_data
);
   logic         full_q;
   logic [W-1:0] data_q;
   logic         load;

   assign up_ready = dn_ready | ~full_q;
   assign load     = up_valid & up_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)         full_q <= 1'b0;
      else if (load)      full_q <= 1'b1;
      else if (dn_ready)  full_q <= 1'b0;
   end

   if (CLEAR_DATA) begin : g_clr
      always_ff @(posedge clk) begin
         if (!rst_n)      data_q <= '0;
         else if (load)   data_q <= up_data;
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (load)        data_q <= up_data;
      end
   end

   assign dn_valid = full_q;
   assign dn_data  = data_q;
endmodule

// File: rtl/modq_addsub.sv
`timescale 1ns/1ps
module modq_addsub #(
   parameter int W          = modq_pkg::MQ_DEF_WIDTH,
   parameter int MODULUS    = modq_pkg::MQ_DEF_MODULUS,
   parameter bit SHARED_ADD = 1'b1,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   input  logic         sub_sel,
   input  logic         in_valid,
   output logic         in_ready,
   output logic [W-1:0] res_data,
   output logic         out_valid,
   input  logic         out_ready
);
   if (W < 2 || W > 30) begin : g_bad_width
      $error("modq_addsub: W out of supported range");
   end
   if (MODULUS < 2 || MODULUS >= (1 << W)) begin : g_bad_mod
      $error("modq_addsub: MODULUS must fit in W bits");
   end

   logic [W-1:0] core_r;

   modq_corr_core #(
      .W(W), .MODULUS(MODULUS), .SHARED_ADD(SHARED_ADD)
   ) u_core (
      .op_sub (sub_sel),
      .a      (opnd_a),
      .b      (opnd_b),
      .r      (core_r)
   );

   modq_hold_stage #(
      .W(W), .CLEAR_DATA(CLEAR_DATA)
   ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (in_valid),
      .up_ready (in_ready),
      .up_data  (core_r),
      .dn_valid (out_valid),
      .dn_ready (out_ready),
      .dn_data  (res_data)
   );
endmodule

// File: rtl/modq_addsub_chk.sv
`timescale 1ns/1ps
module modq_addsub_chk #(
   parameter int W       = modq_pkg::MQ_DEF_WIDTH,
   parameter int MODULUS = modq_pkg::MQ_DEF_MODULUS
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] opnd_a,
   input logic [W-1:0] opnd_b,
   input logic         sub_sel,
   input logic         in_valid,
   input logic         in_ready,
   input logic [W-1:0] res_data,
   input logic         out_valid,
   input logic         out_ready
);
   int           ref_t;
   logic [W-1:0] ref_val;
   logic         accept;

   always_comb begin
      ref_t = sub_sel ? (int'(opnd_a) - int'(opnd_b)) : (int'(opnd_a) + int'(opnd_b));
      if (ref_t < 0)             ref_t = ref_t + MODULUS;
      else if (ref_t >= MODULUS) ref_t = ref_t - MODULUS;
      ref_val = ref_t[W-1:0];
      accept  = in_valid & in_ready;
   end

   AST_OPND_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (int'(opnd_a) < MODULUS && int'(opnd_b) < MODULUS)); // R2
   AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !sub_sel) |=> (res_data == $past(ref_val))); // R2
   AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sub_sel) |=> (res_data == $past(ref_val))); // R3
   AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid); // R4
   AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R5
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(res_data))); // R6
   AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !accept) |=> !out_valid); // R7
   AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(res_data) < MODULUS)); // R3
endmodule

bind modq_addsub modq_addsub_chk #(.W(W), .MODULUS(MODULUS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .sub_sel   (sub_sel),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .res_data  (res_data),
   .out_valid (out_valid),
   .out_ready (out_ready)
);

// File: tb/modq_addsub_bench.sv
`timescale 1ns/1ps
module modq_addsub_bench;
   localparam int W = 12;
   localparam int M = 3329;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic         sub_sel = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [W-1:0] res_data;
   logic         out_valid;
   logic         out_ready = 1'b0;

   int    total = 0;
   int    bad = 0;
   bit    m_valid = 1'b0;
   int    m_data = 0;
   string m_tag = "R2";
   bit    ended = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   modq_addsub u_modq_addsub (
      .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .sub_sel(sub_sel), .in_valid(in_valid), .in_ready(in_ready),
      .res_data(res_data), .out_valid(out_valid), .out_ready(out_ready)
   );

   function automatic int ref_mod(int a, int b, bit s);
      int t;
      t = s ? a - b : a + b;
      if (t < 0)       t = t + M;
      else if (t >= M) t = t - M;
      return t;
   endfunction

   function automatic int pick_opnd();
      int k;
      k = int'($urandom_range(0, 7));
      case (k)
         0: return 0;
         1: return 1;
         2: return M - 1;
         3: return M - 2;
         default: return int'($urandom_range(0, M - 1));
      endcase
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // called at a falling edge: check outputs, then drive the next inputs
   task automatic step(bit v, int a, int b, bit s, bit r, string tag);
      bit acc;
      chk(out_valid == m_valid, "R4 R6 R7 valid", int'(out_valid), int'(m_valid));
      chk(in_ready == (out_ready | ~m_valid), "R5 ready", int'(in_ready),
          int'(out_ready | ~m_valid));
      if (m_valid) chk(int'(res_data) == m_data, m_tag, int'(res_data), m_data);
      in_valid  = v;
      opnd_a    = W'(a);
      opnd_b    = W'(b);
      sub_sel   = s;
      out_ready = r;
      acc = v && (r || !m_valid);
      if (acc) begin
         m_valid = 1'b1;
         m_data  = ref_mod(a, b, s);
         m_tag   = tag;
      end else if (r) begin
         m_valid = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty and ready right after reset, even with out_ready low
      chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

      // R8 corners, back to back with out_ready held high
      step(1, M - 1, M - 1, 0, 1, "R8");
      step(1, M - 1, 1,     0, 1, "R8");
      step(1, 0,     1,     1, 1, "R8");
      step(1, 1234,  1234,  1, 1, "R8");
      step(1, 0,     0,     0, 1, "R8");
      step(0, 0,     0,     0, 1, "R7");
      step(0, 0,     0,     0, 1, "R7");

      // R9: fill under stall, then offer a pair while not ready
      step(1, 5,   7,   0, 0, "R9");
      step(1, 100, 200, 0, 0, "R9");
      step(1, 300, 400, 1, 0, "R9");
      step(0, 0,   0,   0, 0, "R9");
      // R6 release and R7 drain
      step(0, 0,   0,   0, 1, "R6");
      step(0, 0,   0,   0, 1, "R7");

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         bit s;
         s = bit'($urandom_range(0, 1));
         step(($urandom_range(0, 9) < 7), pick_opnd(), pick_opnd(), s,
              ($urandom_range(0, 9) < 6), s ? "R3" : "R2");
      end
      step(0, 0, 0, 0, 1, "R7");
      step(0, 0, 0, 0, 1, "R7");
      finish_run();
   end
endmodule